// File: doc/BRIEF.md
# RMII Transmit Di-bit Serializer

This block turns a byte-wide frame stream from a MAC into the two-bit transmit signalling of a reduced-pin PHY link. All of its logic runs on the 50 MHz reference clock. When a frame's first byte arrives, the block opens the frame itself. It raises the transmit enable, sends a run of preamble symbols and then a single start-of-frame symbol. After that it sends each payload byte as four di-bits, the low pair of bits first. In 10 Mbps mode every di-bit is held for ten reference clocks. In 100 Mbps mode each di-bit lasts one clock. The speed select is read once, when a frame starts.

The byte input is valid/ready. The block holds one byte in a single holding register and takes a new byte only while that register is empty. It empties once per byte period, when the shifter loads from it. Upstream may hold `in_valid` low at any time while `in_ready` is high. The shifter cannot stall in the middle of a frame, though. If the holding register is still empty when the current byte's last di-bit ends, the frame closes at that point. After the byte flagged `in_last`, `in_ready` stays low until the frame has ended and the minimum idle period has passed. After every frame, enable stays low for at least `IDLE_MIN` clocks.

Top module: `rmii_tx_serializer`

## Requirements
- R1: After reset, `txen` is 0, `txd` is 00 and `in_ready` is 1.
- R2: `txen` rises on the same clock that the first preamble di-bit (value 01) appears on `txd`. The preamble is 31 di-bits of 01.
- R3: One di-bit of 11 follows the preamble directly, and the frame's first data di-bit follows it.
- R4: Each byte goes out as four di-bits in the order bits [1:0], [3:2], [5:4], [7:6].
- R5: With `speed_100` = 1 each di-bit lasts one clock. With `speed_100` = 0 each di-bit lasts ten consecutive clocks.
- R6: `speed_100` is sampled when a frame starts. A change during a frame has no effect on that frame's timing.
- R7: `txd` is 00 whenever `txen` is 0. `txen` falls on the clock after the last di-bit of the byte flagged `in_last` ends.
- R8: `in_ready` goes low on the clock after any accepted byte. One byte is taken per byte period.
- R9: Between two frames, `txen` stays low for at least `IDLE_MIN` clocks.
- R10: If no byte is held when a non-last byte's final di-bit ends, the frame ends there, and `txen` falls on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps; sampled at frame start |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | `in_data` and `in_last` are valid |
| in_last | input | 1 | This byte is the last of the frame |
| in_ready | output | 1 | Block takes the byte at this clock edge if `in_valid` is high |
| txen | output | 1 | Transmit enable to the PHY |
| txd | output | 2 | Transmit di-bit to the PHY |

## Verification
A wrong preamble counter or start state shows up straight away. The symbol stream would have the wrong length of 01 run, or the 11 symbol would sit at the wrong position, so the error is visible before any payload di-bit goes out. A wrong shift or di-bit counter corrupts a payload di-bit within one byte period, meaning four clocks at 100 Mbps or forty at 10 Mbps. A wrong pacing counter or speed latch shows at the first di-bit whose hold length is wrong. Errors in the handshake, end-of-frame or idle logic show as extra or missing symbols, or as an early `txen` rise, at the frame's end or at the start of the next frame.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_t;

  localparam logic [1:0] SYM_PRE  = 2'b01;
  localparam logic [1:0] SYM_SFD  = 2'b11;
  localparam logic [1:0] SYM_NONE = 2'b00;
endpackage

// File: rtl/rmii_tx_holdbuf.sv
module rmii_tx_holdbuf #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              allow,
  input  logic              take,
  input  logic              frame_end,
  output logic              full,
  output logic [BYTE_W-1:0] held_data,
  output logic              held_last
);
  logic closing;
  logic accept;

  assign in_ready = !full && !closing && allow;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      closing   <= 1'b0;
      held_data <= '0;
      held_last <= 1'b0;
    end else begin
      if (take) full <= 1'b0;
      if (frame_end) closing <= 1'b0;
      if (accept) begin
        full      <= 1'b1;
        held_data <= in_data;
        held_last <= in_last;
        if (in_last) closing <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmii_tx_pace.sv
module rmii_tx_pace #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  generate
    if (SLOW_DIV > 1) begin : g_div
      localparam int SW = $clog2(SLOW_DIV);
      logic [SW-1:0] sub;
      assign tick = run && (!slow || sub == SW'(SLOW_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) sub <= '0;
        else                        sub <= sub + 1'b1;
      end
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/rmii_tx_seq.sv
module rmii_tx_seq
  import rmii_tx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int PRE_DIBITS = 32,
  parameter int IDLE_MIN   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_100,
  input  logic              tick,
  input  logic              buf_full,
  input  logic [BYTE_W-1:0] buf_data,
  input  logic              buf_last,
  output logic              take,
  output logic              frame_end,
  output logic              allow,
  output logic              run,
  output logic              slow,
  output logic              txen,
  output logic [1:0]        txd
);
  localparam int DPB = BYTE_W / 2;
  localparam int PW  = $clog2(PRE_DIBITS);
  localparam int DW  = (DPB > 1) ? $clog2(DPB) : 1;
  localparam int GW  = $clog2(IDLE_MIN + 1);
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIBITS - 1);
  localparam logic [DW-1:0] DIB_LAST  = DW'(DPB - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(IDLE_MIN - 1);

  tx_state_t         st;
  logic [PW-1:0]     pre_cnt;
  logic [DW-1:0]     dcnt;
  logic [BYTE_W-1:0] sh;
  logic              sh_last;
  logic [GW-1:0]     gcnt;
  logic              pre_done;
  logic              byte_done;

  assign pre_done  = (st == ST_PRE)  && tick && (pre_cnt == PRE_LAST);
  assign byte_done = (st == ST_DATA) && tick && (dcnt == DIB_LAST);
  assign take      = pre_done || (byte_done && !sh_last && buf_full);
  assign frame_end = byte_done && (sh_last || !buf_full);
  assign allow     = (st != ST_GAP);
  assign txen      = (st == ST_PRE) || (st == ST_DATA);
  assign run       = txen;

  always_comb begin
    case (st)
      ST_PRE:  txd = (pre_cnt == PRE_LAST) ? SYM_SFD : SYM_PRE;
      ST_DATA: txd = sh[1:0];
      default: txd = SYM_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pre_cnt <= '0;
      dcnt    <= '0;
      sh      <= '0;
      sh_last <= 1'b0;
      gcnt    <= '0;
      slow    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (buf_full) begin
            st      <= ST_PRE;
            pre_cnt <= '0;
            slow    <= !speed_100;
          end
        end
        ST_PRE: begin
          if (pre_done) begin
            st      <= ST_DATA;
            sh      <= buf_data;
            sh_last <= buf_last;
            dcnt    <= '0;
          end else if (tick) begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (byte_done) begin
            if (take) begin
              sh      <= buf_data;
              sh_last <= buf_last;
              dcnt    <= '0;
            end else begin
              st   <= ST_GAP;
              gcnt <= '0;
            end
          end else if (tick) begin
            sh   <= sh >> 2;
            dcnt <= dcnt + 1'b1;
          end
        end
        default: begin
          if (gcnt == GAP_LAST) st <= ST_IDLE;
          else                  gcnt <= gcnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
  parameter int BYTE_W     = 8,
  parameter int PRE_DIBITS = 32,
  parameter int SLOW_DIV   = 10,
  parameter int IDLE_MIN   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_100,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              txen,
  output logic [1:0]        txd
);
  logic              tick;
  logic              take;
  logic              frame_end;
  logic              allow;
  logic              run;
  logic              slow;
  logic              buf_full;
  logic [BYTE_W-1:0] buf_data;
  logic              buf_last;

  rmii_tx_holdbuf #(.BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .allow(allow), .take(take),
    .frame_end(frame_end), .full(buf_full),
    .held_data(buf_data), .held_last(buf_last)
  );

  rmii_tx_pace #(.SLOW_DIV(SLOW_DIV)) u_pace (
    .clk(clk), .rst_n(rst_n), .run(run), .slow(slow), .tick(tick)
  );

  rmii_tx_seq #(
    .BYTE_W(BYTE_W), .PRE_DIBITS(PRE_DIBITS), .IDLE_MIN(IDLE_MIN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .tick(tick),
    .buf_full(buf_full), .buf_data(buf_data), .buf_last(buf_last),
    .take(take), .frame_end(frame_end), .allow(allow), .run(run),
    .slow(slow), .txen(txen), .txd(txd)
  );
endmodule

// File: rtl/rmii_tx_checker.sv
module rmii_tx_checker #(
  parameter int IDLE_MIN = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txen,
  input logic [1:0] txd
);
  localparam int GW = $clog2(IDLE_MIN + 1);
  localparam logic [GW-1:0] LOW_SAT = GW'(IDLE_MIN);

  logic [GW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               low_cnt <= LOW_SAT;
    else if (txen)            low_cnt <= '0;
    else if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
  end

  // R7: no symbol while enable is low
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !txen |-> txd == 2'b00);

  // R2: enable opens on a preamble symbol
  p_open_preamble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |-> txd == 2'b01);

  // R2: the first byte is already held when enable rises
  p_start_holds_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |-> !in_ready);

  // R8: a take closes ready for the next cycle
  p_one_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: minimum low time before a frame opens
  p_min_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |-> low_cnt >= LOW_SAT);
endmodule

bind rmii_tx_serializer rmii_tx_checker #(.IDLE_MIN(IDLE_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .txen(txen), .txd(txd)
);

// File: tb/rmii_tx_serializer_bench.sv
module rmii_tx_serializer_bench;
  localparam int IDLE_MIN = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100 = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       txen;
  logic [1:0] txd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] q_d[$];
  string      q_t[$];
  logic [7:0] pl[$];

  always #4 clk = ~clk;

  rmii_tx_serializer #(.IDLE_MIN(IDLE_MIN)) u_rmii_tx_serializer (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .txen(txen), .txd(txd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_sym(input logic [1:0] d, input string tag, input bit slow);
    for (int k = 0; k < (slow ? 10 : 1); k++) begin
      q_d.push_back(d);
      q_t.push_back(tag);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input bit last);
    in_data  = b;
    in_last  = last;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R8 ready after take", in_ready, 0);
  endtask

  // driver: pushes the expected symbol stream, then feeds bytes
  task automatic run_frame(input bit slow, input int stall, input bit underrun, input string xtag);
    int n;
    n = underrun ? 1 : pl.size();
    for (int i = 0; i < 31; i++) push_sym(2'b01, {"R2", xtag}, slow);
    push_sym(2'b11, {"R3", xtag}, slow);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 4; j++)
        push_sym(pl[i][2*j +: 2], {"R4", xtag}, slow);
    speed_100 = !slow;
    for (int i = 0; i < n; i++) begin
      if (i > 0) repeat (stall) @(negedge clk);
      put_byte(pl[i], !underrun && (i == n - 1));
    end
    wait (q_d.size() == 0);
    @(negedge clk);
    wait (!txen);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops and compares every cycle
  bit prev_txen = 1'b0;
  bit seen = 1'b0;
  int low_run = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!txen) begin
        check(txd == 2'b00, "R7 idle symbol", txd, 0);
        if (prev_txen)
          check(q_d.size() == 0, "R7/R10 frame end position", q_d.size(), 0);
        low_run++;
      end else begin
        if (!prev_txen && seen)
          check(low_run >= IDLE_MIN, "R9 idle gap", low_run, IDLE_MIN);
        if (q_d.size() == 0) begin
          check(1'b0, "R7 extra symbol", txd, 0);
        end else begin
          logic [1:0] d;
          string t;
          d = q_d.pop_front();
          t = q_t.pop_front();
          check(txd == d, t, txd, d);
        end
        low_run = 0;
        seen = 1'b1;
      end
      prev_txen = txen;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(txen == 1'b0, "R1 txen after reset", txen, 0);
    check(txd == 2'b00, "R1 txd after reset", txd, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // 100 Mbps, mixed byte patterns (R4 order, R5 fast)
    pl = '{8'h1B, 8'hE4, 8'h00, 8'hFF, 8'hA5, 8'h5A};
    run_frame(1'b0, 0, 1'b0, "/R5 fast");

    // 10 Mbps, ten-clock hold (R5)
    pl = '{8'hC3, 8'h96, 8'h71};
    run_frame(1'b1, 0, 1'b0, "/R5 slow");

    // upstream stalls within the byte period (R8)
    pl = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
    run_frame(1'b0, 2, 1'b0, "/R8 stall");

    // speed select flipped mid-frame must not change timing (R6)
    pl = '{8'h3C, 8'hC9};
    fork
      run_frame(1'b1, 0, 1'b0, "/R6 speed flip");
      begin
        repeat (100) @(negedge clk);
        speed_100 = 1'b1;
        repeat (300) @(negedge clk);
        speed_100 = 1'b0;
      end
    join

    // underrun: one non-last byte, then nothing (R10)
    pl = '{8'h6D};
    run_frame(1'b0, 0, 1'b1, "/R10 underrun");

    // single-byte frames back to back (R7, R9)
    pl = '{8'h81};
    run_frame(1'b0, 0, 1'b0, "/R9 single");
    pl = '{8'h42};
    run_frame(1'b0, 0, 1'b0, "/R9 single");

    repeat (20) @(negedge clk);
    check(q_d.size() == 0, "R7 stream drained", q_d.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule